// File: doc/BRIEF.md
# Serial Line Transmitter with Frame Control

This block turns parallel characters into an asynchronous serial frame. It takes one character at a time over a valid/ready input. It then sends a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two high stop bits. Bit timing comes from an external strobe, `tick16`, which pulses sixteen times per bit period. Each bit on the line therefore lasts exactly sixteen strobes.

The frame format is set by plain control pins. Word length, parity mode, stop-bit count, a break request, clear-to-send flow control and a transmit enable are all pins. The frame settings are captured when a character is accepted, so changing them mid-frame does not affect the frame in flight. A busy output tells software that data is still pending upstream, through `hold_empty` low, or that a frame is still on the wire.

Back-pressure works as follows. `in_ready` is high only when all of these hold:
- the engine is idle;
- transmit is enabled;
- no break is requested;
- flow control allows a start.

A character is taken on a clock edge where both `in_valid` and `in_ready` are high. The source may hold `in_valid` high for as long as it likes while `in_ready` is low.

Top module: `uart_tx_line`

## Requirements
- R1: A frame is a low start bit, then N data bits LSB first with N = 5 + `wlen` (`wlen` 00→5, 01→6, 10→7, 11→8), then the stop bit(s) at high level. Every bit lasts 16 pulses of `tick16`.
- R2: When `par_en` is 0, no parity bit is placed between the data and the stop bits.
- R3: When `par_en` is 1 and `par_stick` is 0, a parity bit follows the data. With `par_even` = 1, the count of ones across data plus parity is even. With `par_even` = 0, that count is odd.
- R4: When `par_en` and `par_stick` are both 1, the parity bit is a constant: 1 when `par_even` is 0, and 0 when `par_even` is 1.
- R5: With `two_stop` = 1 the frame ends with two high stop bits; otherwise it ends with one.
- R6: While `send_break` is 1, `txd` is driven low continuously. A frame already in progress still completes first, including its stop bits. `txd` returns high one cycle after `send_break` falls.
- R7: `busy` is 1 whenever `hold_empty` is 0, even when `tx_en` is 0. `busy` is also 1 from acceptance until the last stop bit has ended, and 0 otherwise.
- R8: With `cts_en` = 1, no frame starts while `cts` is 0. Dropping `cts` during a frame does not shorten or alter that frame.
- R9: Clearing `tx_en` during a frame lets the frame finish. After that, no new frame starts and `in_ready` stays 0.
- R10: After reset, and whenever no frame or break is active, `txd` is high.
- R11: `in_ready` is 1 only when idle, `tx_en` = 1, `send_break` = 0 and flow control permits a start. It is 0 for the whole of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit period |
| tx_en | input | 1 | Transmit enable |
| wlen | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit inserted when 1 |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Constant (stick) parity select |
| two_stop | input | 1 | Two stop bits when 1 |
| send_break | input | 1 | Hold the line low after the current frame |
| cts_en | input | 1 | Clear-to-send gating enable |
| cts | input | 1 | Clear-to-send, active high |
| hold_empty | input | 1 | Upstream holds no pending character |
| in_valid | input | 1 | Character offered |
| in_data | input | DW | Character, LSB sent first |
| in_ready | output | 1 | Character will be taken this edge |
| txd | output | 1 | Serial line |
| busy | output | 1 | Pending data or frame in flight |

## Verification
A corrupted shift register or parity latch shows up as a wrong level on `txd` at the middle of a data or parity bit. It appears within one bit period, that is, 16 strobes, of the fault. A wrong bit counter or stop-bit count moves the frame end. `busy` then falls one bit period early or late, and `in_ready` reopens at the wrong edge. A stuck break or flow-control path is visible as soon as the engine is idle: the line stays low, or `in_ready` is held high against `cts`.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BREAK
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
  } line_cfg_t;
endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  output logic bit_end
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  assign bit_end = !hold && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (hold)       cnt <= '0;
    else if (bit_end)    cnt <= '0;
    else if (tick)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]              data,
  input  uart_tx_pkg::line_cfg_t     cfg,
  output logic                       par_bit
);
  localparam int MIN_BITS = DW - 3;

  logic [DW-1:0] masked;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_mask
      if (i < MIN_BITS) begin : g_always
        assign masked[i] = data[i];
      end else begin : g_sel
        assign masked[i] = data[i] && (int'(cfg.wlen) >= (i - MIN_BITS + 1));
      end
    end
  endgenerate

  always_comb begin
    if (cfg.par_stick) par_bit = !cfg.par_even;
    else if (cfg.par_even) par_bit = ^masked;
    else par_bit = ~^masked;
  end
endmodule

// File: rtl/uart_tx_frame_fsm.sv
module uart_tx_frame_fsm
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_end,
  input  logic          accept,
  input  logic          send_break,
  input  logic [DW-1:0] in_data,
  input  line_cfg_t     cfg_in,
  input  logic          par_in,
  output tx_state_e     state,
  output logic          txd
);
  localparam int MIN_BITS = DW - 3;
  localparam int BW = $clog2(DW);

  logic [DW-1:0] shreg;
  logic [BW-1:0] bit_idx;
  line_cfg_t     cfg_q;
  logic          par_q;
  logic          second_stop;
  logic [BW-1:0] last_idx;

  assign last_idx = BW'(MIN_BITS - 1) + BW'(cfg_q.wlen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      bit_idx     <= '0;
      cfg_q       <= '0;
      par_q       <= 1'b0;
      second_stop <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (send_break) begin
            state <= ST_BREAK;
          end else if (accept) begin
            state       <= ST_START;
            shreg       <= in_data;
            cfg_q       <= cfg_in;
            par_q       <= par_in;
            bit_idx     <= '0;
            second_stop <= 1'b0;
          end
        end
        ST_BREAK: if (!send_break) state <= ST_IDLE;
        ST_START: if (bit_end) state <= ST_DATA;
        ST_DATA: if (bit_end) begin
          shreg <= shreg >> 1;
          if (bit_idx == last_idx) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end
        ST_PAR: if (bit_end) state <= ST_STOP;
        ST_STOP: if (bit_end) begin
          if (cfg_q.two_stop && !second_stop) second_stop <= 1'b1;
          else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START, ST_BREAK: txd = 1'b0;
      ST_DATA:            txd = shreg[0];
      ST_PAR:             txd = par_q;
      default:            txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
  import uart_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          tx_en,
  input  logic [1:0]    wlen,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          par_stick,
  input  logic          two_stop,
  input  logic          send_break,
  input  logic          cts_en,
  input  logic          cts,
  input  logic          hold_empty,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          txd,
  output logic          busy
);
  line_cfg_t cfg_now;
  tx_state_e state;
  logic      bit_end;
  logic      par_now;
  logic      accept;
  logic      frame_active;
  logic      cts_ok;

  assign cfg_now = '{wlen: wlen, par_en: par_en, par_even: par_even,
                     par_stick: par_stick, two_stop: two_stop};

  assign cts_ok       = !cts_en || cts;
  assign frame_active = (state != ST_IDLE) && (state != ST_BREAK);
  assign in_ready     = (state == ST_IDLE) && tx_en && !send_break && cts_ok;
  assign accept       = in_valid && in_ready;
  assign busy         = !hold_empty || frame_active;

  uart_tx_bit_timer #(.OVS(OVS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .hold    (!frame_active),
    .bit_end (bit_end)
  );

  uart_tx_parity #(.DW(DW)) u_par (
    .data    (in_data),
    .cfg     (cfg_now),
    .par_bit (par_now)
  );

  uart_tx_frame_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_end    (bit_end),
    .accept     (accept),
    .send_break (send_break),
    .in_data    (in_data),
    .cfg_in     (cfg_now),
    .par_in     (par_now),
    .state      (state),
    .txd        (txd)
  );
endmodule

// File: rtl/uart_tx_line_chk.sv
module uart_tx_line_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic send_break,
  input logic cts_en,
  input logic cts,
  input logic hold_empty,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy,
  input logic frame_active
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && !cts) |-> !in_ready);

  p_disabled_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !in_ready);

  p_pending_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_empty |-> busy);

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !frame_active);

  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!txd && busy));

  p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(send_break) && $past(!frame_active) && !frame_active) |-> !txd);

  p_marking_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !frame_active && !send_break && $past(!send_break)) |-> txd);
endmodule

bind uart_tx_line uart_tx_line_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_en        (tx_en),
  .send_break   (send_break),
  .cts_en       (cts_en),
  .cts          (cts),
  .hold_empty   (hold_empty),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .txd          (txd),
  .busy         (busy),
  .frame_active (frame_active)
);

// File: tb/tb_uart_tx_line.sv
module tb_uart_tx_line;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic tx_en = 1'b1;
  logic [1:0] wlen = 2'b11;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, two_stop = 1'b0;
  logic send_break = 1'b0, cts_en = 1'b0, cts = 1'b0;
  logic hold_empty = 1'b1, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, txd, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int BITC = 32;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

  uart_tx_line dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .two_stop(two_stop), .send_break(send_break), .cts_en(cts_en), .cts(cts),
    .hold_empty(hold_empty), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int build_frame(input logic [7:0] d, output logic [11:0] b);
    int n = 0;
    int nd = 5 + int'(wlen);
    int ones = 0;
    b = '1;
    b[n++] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      b[n++] = d[i];
      ones += int'(d[i]);
    end
    if (par_en) begin
      if (par_stick) b[n++] = ~par_even;
      else b[n++] = par_even ? ((ones % 2) == 1) : ((ones % 2) == 0);
    end
    b[n++] = 1'b1;
    if (two_stop) b[n++] = 1'b1;
    return n;
  endfunction

  // kind: 0 none, 1 break on, 2 cts drop, 3 tx_en off (applied mid bit ev)
  task automatic send_frame(input logic [7:0] d, input int ev, input int kind);
    logic [11:0] b;
    int n, t, nd;
    string tag;
    n = build_frame(d, b);
    nd = 5 + int'(wlen);
    in_data = d;
    in_valid = 1'b1;
    hold_empty = 1'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    hold_empty = 1'b1;
    t = 0;
    for (int k = 0; k < n; k++) begin
      while (t < k * BITC + 16) begin @(negedge clk); t++; end
      if (k == 0) tag = "R1 start";
      else if (k <= nd) tag = "R1 data";
      else if (par_en && k == nd + 1) tag = par_stick ? "R4 stick parity" : "R3 parity";
      else if (k == n - 1 && two_stop) tag = "R5 second stop";
      else tag = par_en ? "R1 stop" : "R2 stop follows data";
      chk(txd == b[k], tag, int'(txd), int'(b[k]));
      chk(busy == 1'b1, "R7 busy in frame", int'(busy), 1);
      chk(in_ready == 1'b0, "R11 ready low in frame", int'(in_ready), 0);
      if (k == ev) begin
        if (kind == 1) send_break = 1'b1;
        if (kind == 2) cts = 1'b0;
        if (kind == 3) tx_en = 1'b0;
      end
    end
    while (t < n * BITC - 4) begin @(negedge clk); t++; end
    chk(busy == 1'b1, "R7 busy through last stop", int'(busy), 1);
    while (t < n * BITC + 4) begin @(negedge clk); t++; end
    chk(busy == 1'b0, "R7 busy falls after frame", int'(busy), 0);
    chk(txd == (kind != 1), kind == 1 ? "R6 break after frame" : "R10 idle marking",
        int'(txd), int'(kind != 1));
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R10 reset line high", int'(txd), 1);
    chk(busy == 1'b0, "R7 reset busy low", int'(busy), 0);
    chk(in_ready == 1'b1, "R11 reset ready", int'(in_ready), 1);

    // directed: word lengths, parity modes, stop counts
    for (int w = 0; w < 4; w++) begin
      wlen = 2'(w); par_en = 0; two_stop = 0;
      send_frame(8'hA5, -1, 0);
    end
    wlen = 2'b11; par_en = 1; par_stick = 0; par_even = 1; send_frame(8'h07, -1, 0);
    par_even = 0; send_frame(8'h07, -1, 0);
    par_stick = 1; par_even = 0; send_frame(8'h00, -1, 0);
    par_even = 1; send_frame(8'hFF, -1, 0);
    par_en = 0; par_stick = 0; two_stop = 1; send_frame(8'h3C, -1, 0);

    // random frames
    for (int i = 0; i < 20; i++) begin
      wlen = 2'($urandom_range(0, 3));
      par_en = 1'($urandom); par_even = 1'($urandom);
      par_stick = 1'($urandom); two_stop = 1'($urandom);
      send_frame(8'($urandom), -1, 0);
    end

    // break requested mid frame
    wlen = 2'b11; par_en = 0; two_stop = 0;
    send_frame(8'h81, 3, 1);
    repeat (100) @(negedge clk);
    chk(txd == 1'b0, "R6 break held low", int'(txd), 0);
    chk(in_ready == 1'b0, "R11 no ready in break", int'(in_ready), 0);
    send_break = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R6 line released after break", int'(txd), 1);

    // flow control gating
    cts_en = 1; cts = 0; in_data = 8'h55; in_valid = 1; hold_empty = 0;
    for (int i = 0; i < 10; i++) begin
      repeat (20) @(negedge clk);
      chk(txd == 1'b1, "R8 no start without cts", int'(txd), 1);
      chk(in_ready == 1'b0, "R8 ready gated", int'(in_ready), 0);
    end
    chk(busy == 1'b1, "R7 busy on pending data", int'(busy), 1);
    cts = 1;
    send_frame(8'h55, 4, 2);
    cts_en = 0;

    // disable mid frame
    send_frame(8'hC3, 5, 3);
    in_valid = 1; hold_empty = 0;
    for (int i = 0; i < 10; i++) begin
      repeat (20) @(negedge clk);
      chk(txd == 1'b1, "R9 no start when disabled", int'(txd), 1);
      chk(in_ready == 1'b0, "R9 ready low when disabled", int'(in_ready), 0);
      chk(busy == 1'b1, "R7 busy while disabled with data", int'(busy), 1);
    end
    in_valid = 0; hold_empty = 1;

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule